// File: doc/BRIEF.md
# Dual-Lane Sixteen-Bit Multiply-Accumulate Unit

This block multiplies and accumulates two pairs of signed 16-bit values in every cycle. Each 32-bit operand word carries two 16-bit values, one in its upper half and one in its lower half. Two independent multiply-accumulate lanes share those words, so four 16-bit inputs are consumed on each accepted cycle. Dot-product and filter kernels therefore finish in half the iterations that a single lane would need.

Lane 1 owns accumulator `acc1_o` and lane 0 owns `acc0_o`. Both accumulators are 40 bits wide, which gives eight guard bits above a full-scale product. A pairing input chooses which halves each lane multiplies. A clear input empties both accumulators at once before a new kernel starts. A combined 41-bit output gives the total of the two lanes, so a whole dot product can be read in one step.

A two-state controller tracks whether the accumulators hold zero (`ST_EMPTY`) or a running total (`ST_ACTIVE`). In each cycle it issues one of four commands to both lanes: `CMD_HOLD`, `CMD_ZERO`, `CMD_LOAD` or `CMD_ADD`. Its transitions are:
- **T_START**: `ST_EMPTY` to `ST_ACTIVE` when `valid_i` is high.
- **T_FLUSH**: `ST_ACTIVE` to `ST_EMPTY` when `clear_i` is high and `valid_i` is low.
- **T_RESTART**: `ST_ACTIVE` stays in `ST_ACTIVE` and loads the products when `clear_i` and `valid_i` are both high.
- **T_IDLE**: the state is kept when neither input is high.

Top module: `dual_mac16`

## Requirements
- R1: While `rst_n` is low, `acc0_o`, `acc1_o` and `sum_o` are all zero.
- R2: With `cross_i`=0 and `valid_i`=1, `clear_i`=0, the next cycle has `acc1_o` increased by x[31:16]*y[31:16] and `acc0_o` increased by x[15:0]*y[15:0].
- R3: With `cross_i`=1 and `valid_i`=1, `clear_i`=0, the next cycle has `acc1_o` increased by x[15:0]*y[15:0] and `acc0_o` increased by x[31:16]*y[31:16].
- R4: With `valid_i`=0 and `clear_i`=0, both accumulators keep their values, whatever the operand and pairing inputs are.
- R5: With `clear_i`=1 and `valid_i`=0, both accumulators are zero in the next cycle.
- R6: With `clear_i`=1 and `valid_i`=1, each accumulator takes its lane's product in the next cycle, and no earlier total is added.
- R7: The 16-bit halves are two's-complement signed. For example, 0x8000*0x8000 adds +2^30 and 0xFFFF*0x0001 adds -1.
- R8: The accumulators wrap modulo 2^40 with no saturation. Adding 2^30 in 512 cycles, starting from zero, gives -2^39.
- R9: `sum_o` always equals the sign-extended `acc0_o` plus the sign-extended `acc1_o`, in 41 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_i | input | 32 | First operand word: two packed 16-bit values |
| y_i | input | 32 | Second operand word: two packed 16-bit values |
| valid_i | input | 1 | Accept the operands in this cycle |
| clear_i | input | 1 | Empty both accumulators |
| cross_i | input | 1 | 0: high×high into acc1, low×low into acc0; 1: the two lanes swapped |
| acc0_o | output | 40 | Lane 0 accumulator |
| acc1_o | output | 40 | Lane 1 accumulator |
| sum_o | output | 41 | acc0 + acc1, sign-extended |

## Verification
The bench sweeps operand halves drawn from a set of extreme and small values: zero, ±1, ±2, the most positive value, the most negative value and an odd value. It runs each combination in both pairing modes. A design that treated the halves as unsigned, or that swapped the lane routing, would put a wrong total on the affected accumulator.

Clear with valid must load the products and must not add them to the old totals. Clear alone must zero both lanes, and an idle cycle with live operands must change nothing. A long run of full-scale products checks the 40-bit wrap and the 41-bit combined sum. A design that saturated, or that dropped the sign extension in the sum, would read back a different number.

// File: rtl/dual_mac16_pkg.sv
package dual_mac16_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_ZERO = 2'd1,
        CMD_LOAD = 2'd2,
        CMD_ADD  = 2'd3
    } acc_cmd_t;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_ACTIVE = 1'b1
    } ctrl_state_t;
endpackage

// File: rtl/dual_mac16_ctrl.sv
module dual_mac16_ctrl
    import dual_mac16_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid_i,
    input  logic     clear_i,
    output acc_cmd_t cmd_o
);
    ctrl_state_t state_q;
    ctrl_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and command
    always_comb begin
        state_d = state_q;
        cmd_o   = CMD_HOLD;
        unique case (state_q)
            ST_EMPTY: begin
                if (valid_i) begin
                    // T_START: an empty accumulator takes the product directly
                    cmd_o   = CMD_LOAD;
                    state_d = ST_ACTIVE;
                end else if (clear_i) begin
                    cmd_o = CMD_ZERO;
                end
            end
            ST_ACTIVE: begin
                if (clear_i && valid_i) begin
                    // T_RESTART
                    cmd_o = CMD_LOAD;
                end else if (clear_i) begin
                    // T_FLUSH
                    cmd_o   = CMD_ZERO;
                    state_d = ST_EMPTY;
                end else if (valid_i) begin
                    cmd_o = CMD_ADD;
                end
            end
            default: begin
                state_d = ST_EMPTY;
                cmd_o   = CMD_ZERO;
            end
        endcase
    end
endmodule

// File: rtl/dual_mac16_route.sv
module dual_mac16_route #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] x_i,
    input  logic [2*HALF_W-1:0] y_i,
    input  logic                cross_i,
    output logic [HALF_W-1:0]   l0_a_o,
    output logic [HALF_W-1:0]   l0_b_o,
    output logic [HALF_W-1:0]   l1_a_o,
    output logic [HALF_W-1:0]   l1_b_o
);
    logic [HALF_W-1:0] x_lo, x_hi, y_lo, y_hi;

    always_comb begin
        x_lo = x_i[HALF_W-1:0];
        x_hi = x_i[2*HALF_W-1:HALF_W];
        y_lo = y_i[HALF_W-1:0];
        y_hi = y_i[2*HALF_W-1:HALF_W];
        if (cross_i) begin
            l0_a_o = x_hi;
            l0_b_o = y_hi;
            l1_a_o = x_lo;
            l1_b_o = y_lo;
        end else begin
            l0_a_o = x_lo;
            l0_b_o = y_lo;
            l1_a_o = x_hi;
            l1_b_o = y_hi;
        end
    end
endmodule

// File: rtl/dual_mac16_lane.sv
module dual_mac16_lane
    import dual_mac16_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] a_i,
    input  logic [HALF_W-1:0] b_i,
    input  acc_cmd_t          cmd_i,
    output logic [ACC_W-1:0]  acc_o
);
    localparam int PROD_W  = 2 * HALF_W;
    localparam int GUARD_W = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;
    logic        [ACC_W-1:0]  prod_ext;
    logic        [ACC_W-1:0]  acc_q;

    always_comb begin
        prod     = $signed(a_i) * $signed(b_i);
        prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            unique case (cmd_i)
                CMD_HOLD: acc_q <= acc_q;
                CMD_ZERO: acc_q <= '0;
                CMD_LOAD: acc_q <= prod_ext;
                CMD_ADD:  acc_q <= acc_q + prod_ext;
                default:  acc_q <= acc_q;
            endcase
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/dual_mac16.sv
module dual_mac16
    import dual_mac16_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40,
    parameter int LANES  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*HALF_W-1:0] x_i,
    input  logic [2*HALF_W-1:0] y_i,
    input  logic                valid_i,
    input  logic                clear_i,
    input  logic                cross_i,
    output logic [ACC_W-1:0]    acc0_o,
    output logic [ACC_W-1:0]    acc1_o,
    output logic [ACC_W:0]      sum_o
);
    acc_cmd_t          cmd;
    logic [HALF_W-1:0] op_a [LANES];
    logic [HALF_W-1:0] op_b [LANES];
    logic [ACC_W-1:0]  acc  [LANES];

    dual_mac16_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .clear_i (clear_i),
        .cmd_o   (cmd)
    );

    dual_mac16_route #(.HALF_W(HALF_W)) u_route (
        .x_i     (x_i),
        .y_i     (y_i),
        .cross_i (cross_i),
        .l0_a_o  (op_a[0]),
        .l0_b_o  (op_b[0]),
        .l1_a_o  (op_a[1]),
        .l1_b_o  (op_b[1])
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dual_mac16_lane #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .a_i   (op_a[g]),
            .b_i   (op_b[g]),
            .cmd_i (cmd),
            .acc_o (acc[g])
        );
    end

    assign acc0_o = acc[0];
    assign acc1_o = acc[1];
    assign sum_o  = {acc[0][ACC_W-1], acc[0]} + {acc[1][ACC_W-1], acc[1]};
endmodule

// File: rtl/dual_mac16_chk.sv
module dual_mac16_chk #(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*HALF_W-1:0] x_i,
    input logic [2*HALF_W-1:0] y_i,
    input logic                valid_i,
    input logic                clear_i,
    input logic                cross_i,
    input logic [ACC_W-1:0]    acc0_o,
    input logic [ACC_W-1:0]    acc1_o,
    input logic [ACC_W:0]      sum_o
);
    logic signed [ACC_W-1:0] p_lo, p_hi;

    always_comb begin
        p_lo = ACC_W'($signed(x_i[HALF_W-1:0]) * $signed(y_i[HALF_W-1:0]));
        p_hi = ACC_W'($signed(x_i[2*HALF_W-1:HALF_W]) * $signed(y_i[2*HALF_W-1:HALF_W]));
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |-> (acc0_o == '0 && acc1_o == '0));

    a_r2_straight_add: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i && !cross_i) |=>
        (acc1_o == $past(acc1_o) + $past(p_hi)) && (acc0_o == $past(acc0_o) + $past(p_lo)));

    a_r3_cross_add: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i && cross_i) |=>
        (acc1_o == $past(acc1_o) + $past(p_lo)) && (acc0_o == $past(acc0_o) + $past(p_hi)));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clear_i) |=> ($stable(acc0_o) && $stable(acc1_o)));

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !valid_i) |=> (acc0_o == '0 && acc1_o == '0));

    a_r6_clear_load: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && valid_i) |=>
        (acc0_o == ($past(cross_i) ? $past(p_hi) : $past(p_lo))) &&
        (acc1_o == ($past(cross_i) ? $past(p_lo) : $past(p_hi))));

    a_r9_sum_total: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(sum_o) == $signed(acc0_o) + $signed(acc1_o));
endmodule

bind dual_mac16 dual_mac16_chk #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_i     (x_i),
    .y_i     (y_i),
    .valid_i (valid_i),
    .clear_i (clear_i),
    .cross_i (cross_i),
    .acc0_o  (acc0_o),
    .acc1_o  (acc1_o),
    .sum_o   (sum_o)
);

// File: tb/dual_mac16_test.sv
module dual_mac16_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] x_i = '0;
    logic [31:0] y_i = '0;
    logic        valid_i = 1'b0;
    logic        clear_i = 1'b0;
    logic        cross_i = 1'b0;
    logic [39:0] acc0_o, acc1_o;
    logic [40:0] sum_o;

    int checks = 0;
    int fails  = 0;
    logic signed [39:0] m0 = '0;
    logic signed [39:0] m1 = '0;
    logic signed [15:0] vals [8];

    always #(PERIOD/2) clk = ~clk;

    dual_mac16 uut (
        .clk(clk), .rst_n(rst_n), .x_i(x_i), .y_i(y_i),
        .valid_i(valid_i), .clear_i(clear_i), .cross_i(cross_i),
        .acc0_o(acc0_o), .acc1_o(acc1_o), .sum_o(sum_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [40:0] act, input logic [40:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic signed [40:0] s;
        s = 41'(m0) + 41'(m1);
        check(tag, "acc0", {1'b0, acc0_o}, {1'b0, m0});
        check(tag, "acc1", {1'b0, acc1_o}, {1'b0, m1});
        check("R9", "sum", sum_o, s);
    endtask

    // Called at a negedge: drive, let one posedge pass, check at next negedge.
    task automatic step(input logic [31:0] x, input logic [31:0] y,
                        input logic v, input logic c, input logic m, input string tag);
        logic signed [39:0] plo, phi, l0, l1;
        x_i = x; y_i = y; valid_i = v; clear_i = c; cross_i = m;
        plo = 40'(int'($signed(x[15:0])) * int'($signed(y[15:0])));
        phi = 40'(int'($signed(x[31:16])) * int'($signed(y[31:16])));
        l0 = m ? phi : plo;
        l1 = m ? plo : phi;
        if (c && v) begin
            m0 = l0; m1 = l1;
        end else if (c) begin
            m0 = '0; m1 = '0;
        end else if (v) begin
            m0 = m0 + l0; m1 = m1 + l1;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        vals[0] = 16'sd0;     vals[1] = 16'sd1;      vals[2] = -16'sd1;  vals[3] = 16'sd2;
        vals[4] = -16'sd2;    vals[5] = 16'sd32767;  vals[6] = -16'sd32768; vals[7] = 16'sd1235;

        // R1: reset state, with live inputs
        x_i = 32'h1234_5678; y_i = 32'h8765_4321; valid_i = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1");
        valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R7: signed corner products
        step({16'h8000, 16'hFFFF}, {16'h8000, 16'h0001}, 1'b1, 1'b0, 1'b0, "R7");
        check("R7", "acc1 2^30", {1'b0, acc1_o}, 41'h0_0040_0000_00);
        check("R7", "acc0 -1", {1'b0, acc0_o}, {1'b0, 40'hFF_FFFF_FFFF});

        // R5: clear alone
        step(32'hFFFF_FFFF, 32'h7FFF_7FFF, 1'b0, 1'b1, 1'b0, "R5");

        // R2 / R3: sweep both pairings over all value pairs
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    step({vals[a], vals[b]}, {vals[b], vals[7-a]}, 1'b1, 1'b0,
                         1'(m), (m == 0) ? "R2" : "R3");
                end
            end
        end

        // R4: idle cycles with changing operands and pairing
        for (int k = 0; k < 6; k++) begin
            step({vals[k], vals[k+1]}, {vals[k+2], vals[k]}, 1'b0, 1'b0, 1'(k), "R4");
        end

        // R6: clear with valid loads the products, both pairings
        step({16'sd300, -16'sd7}, {16'sd11, 16'sd5}, 1'b1, 1'b1, 1'b0, "R6");
        check("R6", "acc1 load", {1'b0, acc1_o}, 41'd3300);
        step({16'sd300, -16'sd7}, {16'sd11, 16'sd5}, 1'b1, 1'b1, 1'b1, "R6");
        check("R6", "acc1 cross load", {1'b0, acc1_o}, {1'b0, 40'hFF_FFFF_FFDD});

        // R8: wrap after 512 full-scale products
        step(32'h0, 32'h0, 1'b0, 1'b1, 1'b0, "R5");
        for (int k = 0; k < 512; k++) begin
            step(32'h8000_8000, 32'h8000_8000, 1'b1, 1'b0, 1'b0, "R8");
        end
        check("R8", "acc1 wrapped", {1'b0, acc1_o}, {1'b0, 40'h80_0000_0000});
        check("R8", "acc0 wrapped", {1'b0, acc0_o}, {1'b0, 40'h80_0000_0000});
        check("R9", "sum wrapped", sum_o, 41'h100_0000_0000);
        step(32'h8000_8000, 32'h8000_8000, 1'b1, 1'b0, 1'b1, "R8");

        // R1: reset mid-run
        rst_n = 1'b0;
        m0 = '0; m1 = '0;
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        step(32'h0003_0004, 32'h0005_0006, 1'b1, 1'b0, 1'b0, "R2");

        finish_run();
    end
endmodule